// File: doc/BRIEF.md
# Two-wire serial EEPROM-style target

This block is the bus-facing engine of a byte-addressed, serial-EEPROM-style memory. It samples the open-drain clock and data lines with the system clock and finds start, stop and repeated-start conditions. It shifts bytes in and out most significant bit first and pulls the data line low through an output enable to acknowledge or to send zeros. An eight-bit word pointer is shared by reads and writes.

Write transactions hand each received byte to a page-buffer port together with its word address. A commit pulse follows when the host closes the write with a stop. Read transactions fetch bytes from a memory read port that is addressed by the pointer. While the memory side reports a timed write in progress, the engine refuses to acknowledge its address, so the host can poll until the write has finished.

Top module: `twi_eeprom_target`

## Requirements
- R1: The first byte after a start is a selector byte. Bits 7..4 must be 1010 and bits 3..1 must equal `dev_sel`. Bit 0 selects the direction: 1 is a read and 0 is a write. A selector byte with the wrong code or the wrong select bits is not acknowledged.
- R2: After a selector byte that does not match, the engine leaves the data line released and ignores all further bytes until the next start. It produces no write or commit in that time.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both lines pass through two-flop synchronizers, and received bits are taken on rising SCL. `sda_oe` is asserted only after a falling SCL. Out of reset `sda_oe`, `wr_valid` and `wr_commit` are low.
- R4: Every byte the engine receives after a matching selector is acknowledged: SDA is held low through the ninth clock and released after that clock falls.
- R5: In a write, the first byte after the selector loads the word pointer. Each later byte gives a one-cycle `wr_valid` carrying the byte in `wr_data` and the pointer in `wr_addr`, and then the pointer advances.
- R6: Several data bytes may follow in one write (page write). `wr_commit` pulses once on a stop that ends a write holding at least one data byte. A repeated start or a write with no data byte gives no commit.
- R7: The pointer keeps its value between transactions. It advances by one for every byte written or sent, and it wraps from FFh to 00h.
- R8: A read with no word address first returns the byte at the current pointer, sent most significant bit first. Each bit changes only while SCL is low.
- R9: During a read the engine sends further bytes while the host acknowledges. After a host not-acknowledge it releases SDA and waits for a stop or a start.
- R10: A write that carries only the word address, followed by a repeated start and a read selector, returns data starting at that word address.
- R11: While `mem_busy` is high, a matching selector byte is not acknowledged.
- R12: A start in any state, including partway through a byte being sent, resets the engine to receive a selector byte. The host can recover by clocking with SDA released until the line reads high, then issuing a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the bus clock line |
| sda_i | input | 1 | Level of the bus data line |
| sda_oe | output | 1 | When high, pulls the data line low |
| dev_sel | input | 3 | Strapped select bits compared with selector bits 3..1 |
| mem_busy | input | 1 | Memory timed write in progress |
| rd_addr | output | 8 | Read port address (current word pointer) |
| rd_data | input | 8 | Read port data at `rd_addr` |
| wr_valid | output | 1 | One-cycle pulse carrying a received data byte |
| wr_addr | output | 8 | Word address of the byte on `wr_data` |
| wr_data | output | 8 | Received data byte |
| wr_commit | output | 1 | One-cycle pulse: latch the page buffer and start the timed write |

## Verification
The bench targets the pointer wrap at FFh in both a page write and a sequential read. A design that got this wrong would write or return bytes from address 100h or from the start of the page. It polls the address right after each commit; a design that ignores `mem_busy` would acknowledge the host while the memory write is still running. A write interrupted by a repeated start must not commit, and a leaked commit would show up as memory contents the host never finished. An aborted read, where the engine is still driving zeros, must be recoverable by clocking and a start; an engine that misses the start would stay silent on the next selector.

// File: rtl/twi_tgt_pkg.sv
package twi_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [3:0] CTRL_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } eng_st_e;

  typedef enum logic [1:0] {
    RK_SEL,
    RK_WADDR,
    RK_WDATA
  } rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [1:0] raw;
  logic [1:0] cur;
  logic [1:0] prv;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH-1:0] pipe_d;

    always_comb pipe_d = {pipe_q[DEPTH-2:0], raw[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign cur[g] = pipe_q[DEPTH-2];
    assign prv[g] = pipe_q[DEPTH-1];
  end

  assign sda_lvl   = cur[1];
  assign scl_rise  = cur[0] & ~prv[0];
  assign scl_fall  = ~cur[0] & prv[0];
  assign bus_start = cur[0] & prv[0] & prv[1] & ~cur[1];
  assign bus_stop  = cur[0] & prv[0] & ~prv[1] & cur[1];
endmodule

// File: rtl/twi_word_ptr.sv
module twi_word_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (load)     ptr_d = load_val;
    else if (inc) ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/twi_tgt_fsm.sv
module twi_tgt_fsm
  import twi_tgt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [2:0]        dev_sel,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              ptr_load,
  output logic [BYTE_W-1:0] ptr_val,
  output logic              ptr_inc,
  output logic              sda_oe,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  eng_st_e           st_q, st_d;
  rx_kind_e          kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              rw_q, rw_d;
  logic              hack_q, hack_d;
  logic              pend_q, pend_d;
  logic              wrv_q, wrv_d;
  logic              wrc_q, wrc_d;
  logic [BYTE_W-1:0] wadr_q, wadr_d;
  logic [BYTE_W-1:0] wdat_q, wdat_d;
  logic              sel_ok;

  assign sel_ok = (sh_q[7:4] == CTRL_CODE) && (sh_q[3:1] == dev_sel) && !busy_i;

  always_comb begin
    st_d     = st_q;
    kind_d   = kind_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    hack_d   = hack_q;
    pend_d   = pend_q;
    wadr_d   = wadr_q;
    wdat_d   = wdat_q;
    wrv_d    = 1'b0;
    wrc_d    = 1'b0;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    ptr_val  = sh_q;
    if (bus_start) begin
      st_d   = ST_RX;
      kind_d = RK_SEL;
      cnt_d  = '0;
      oe_d   = 1'b0;
      pend_d = 1'b0;
    end else if (bus_stop) begin
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
      wrc_d  = pend_q;
      pend_d = 1'b0;
    end else begin
      case (st_q)
        ST_RX: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + CNT_W'(1);
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            case (kind_q)
              RK_SEL: begin
                if (sel_ok) begin
                  rw_d = sh_q[0];
                  oe_d = 1'b1;
                  st_d = ST_RX_ACK;
                end else begin
                  st_d = ST_IDLE;
                end
              end
              RK_WADDR: begin
                ptr_load = 1'b1;
                oe_d     = 1'b1;
                st_d     = ST_RX_ACK;
              end
              default: begin
                wrv_d   = 1'b1;
                wadr_d  = ptr;
                wdat_d  = sh_q;
                ptr_inc = 1'b1;
                pend_d  = 1'b1;
                oe_d    = 1'b1;
                st_d    = ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (kind_q == RK_SEL && rw_q) begin
              st_d    = ST_TX;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              ptr_inc = 1'b1;
            end else begin
              oe_d   = 1'b0;
              st_d   = ST_RX;
              kind_d = (kind_q == RK_SEL) ? RK_WADDR : RK_WDATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              oe_d = 1'b0;
              st_d = ST_TX_ACK;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              oe_d  = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) hack_d = ~sda_lvl;
          if (scl_fall) begin
            if (hack_q) begin
              st_d    = ST_TX;
              cnt_d   = '0;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              ptr_inc = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= RK_SEL;
      cnt_q  <= '0;
      sh_q   <= '0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      hack_q <= 1'b0;
      pend_q <= 1'b0;
      wrv_q  <= 1'b0;
      wrc_q  <= 1'b0;
      wadr_q <= '0;
      wdat_q <= '0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      oe_q   <= oe_d;
      rw_q   <= rw_d;
      hack_q <= hack_d;
      pend_q <= pend_d;
      wrv_q  <= wrv_d;
      wrc_q  <= wrc_d;
      wadr_q <= wadr_d;
      wdat_q <= wdat_d;
    end
  end

  assign sda_oe    = oe_q;
  assign wr_valid  = wrv_q;
  assign wr_addr   = wadr_q;
  assign wr_data   = wdat_q;
  assign wr_commit = wrc_q;

  // R3: the data line is only ever pulled low following a falling SCL
  assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R11: a selector byte completing while busy leaves the line released
  assert_busy_nack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RX && kind_q == RK_SEL && cnt_q == CNT_FULL && scl_fall &&
     busy_i && !bus_start && !bus_stop) |=> !sda_oe);

  // R6: a commit only ever follows a stop condition
  assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(bus_stop));

  // R5: a write byte is handed over just after a falling SCL
  assert_wr_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(scl_fall));
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
  import twi_tgt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  input  logic              mem_busy,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              bus_start;
  logic              bus_stop;
  logic              ptr_load;
  logic              ptr_inc;
  logic [BYTE_W-1:0] ptr_val;
  logic [BYTE_W-1:0] ptr;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  twi_word_ptr #(.PTR_W(BYTE_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ptr_load),
    .load_val(ptr_val),
    .inc     (ptr_inc),
    .ptr     (ptr)
  );

  twi_tgt_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_lvl),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .dev_sel  (dev_sel),
    .busy_i   (mem_busy),
    .ptr      (ptr),
    .rd_data  (rd_data),
    .ptr_load (ptr_load),
    .ptr_val  (ptr_val),
    .ptr_inc  (ptr_inc),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_commit(wr_commit)
  );

  assign rd_addr = ptr;

  // R7: the pointer seen by the read port is one past each handed-over write byte
  assert_ptr_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> rd_addr == wr_addr + BYTE_W'(1));
endmodule

// File: tb/twi_eeprom_target_test.sv
module twi_eeprom_target_test;
  localparam int Q    = 6;
  localparam int BUSY = 400;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic sda_bus;
  logic [7:0] rd_addr, rd_data, wr_addr, wr_data;
  logic wr_valid, wr_commit;
  logic mem_busy;

  always #10 clk = ~clk;

  assign sda_bus = sda_h & ~sda_oe;

  twi_eeprom_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(SEL), .mem_busy(mem_busy), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
  );

  // memory model fed by the design's write port
  logic [7:0] mem [0:255];
  logic [7:0] cap_a [0:31];
  logic [7:0] cap_d [0:31];
  int cap_n = 0;
  int n_commit = 0;
  int busy_cnt = 0;
  int flush_tok = 0;
  int flush_seen = 0;

  assign rd_data  = mem[rd_addr];
  assign mem_busy = (busy_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 256; k++) mem[k] = 8'(k * 7 + 3);
    end
    if (flush_seen != flush_tok) begin
      cap_n = 0;
      flush_seen = flush_tok;
    end
    if (wr_valid && cap_n < 32) begin
      cap_a[cap_n] = wr_addr;
      cap_d[cap_n] = wr_data;
      cap_n++;
    end
    if (wr_commit) begin
      n_commit++;
      for (int k = 0; k < cap_n; k++) mem[cap_a[k]] = cap_d[k];
      cap_n = 0;
      busy_cnt = BUSY;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
    end
  end

  // bench expectations
  logic [7:0] refm [0:255];
  logic [7:0] wbuf [0:7];
  logic [7:0] exp_ptr = 8'h00;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_h = 1'b0; sda_h = 1'b1; tq();
    scl_h = 1'b1; tq();
    sda_h = 1'b0; tq();
    scl_h = 1'b0; tq();
  endtask

  task automatic bus_stop();
    scl_h = 1'b0; sda_h = 1'b0; tq();
    scl_h = 1'b1; tq();
    sda_h = 1'b1; tq();
    tq();
  endtask

  task automatic wbit(input bit b);
    sda_h = b; tq();
    scl_h = 1'b1; tq(); tq();
    scl_h = 1'b0; tq();
  endtask

  task automatic rbit(output bit v);
    sda_h = 1'b1; tq();
    scl_h = 1'b1; tq();
    v = sda_bus; tq();
    scl_h = 1'b0; tq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    bit v;
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    rbit(v);
    ack = !v;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] b);
    bit v;
    for (int i = 7; i >= 0; i--) begin
      rbit(v);
      b[i] = v;
    end
    wbit(!host_ack);
  endtask

  function automatic logic [7:0] selb(input bit rw);
    return {4'b1010, SEL, rw};
  endfunction

  // page write, stop, commit check, then acknowledge polling
  task automatic do_write(input logic [7:0] a, input int n);
    bit ack;
    int c0;
    c0 = n_commit;
    bus_start();
    send_byte(selb(1'b0), ack);
    chk(ack, "R1", "write selector ack", ack, 1);
    send_byte(a, ack);
    chk(ack, "R4", "word address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack, "R4", "data byte ack", ack, 1);
    end
    bus_stop();
    tq();
    chk(n_commit == c0 + 1, "R6", "one commit after stop", n_commit - c0, 1);
    for (int i = 0; i < n; i++) begin
      refm[8'(a + 8'(i))] = wbuf[i];
      chk(mem[8'(a + 8'(i))] == wbuf[i], "R5", "written byte", mem[8'(a + 8'(i))], wbuf[i]);
    end
    exp_ptr = 8'(a + 8'(n));
    bus_start();
    send_byte(selb(1'b0), ack);
    chk(!ack, "R11", "no ack while busy", ack, 0);
    bus_stop();
    for (int t = 0; t < 20; t++) begin
      bus_start();
      send_byte(selb(1'b0), ack);
      bus_stop();
      if (ack) break;
    end
    chk(ack, "R11", "ack after timed write", ack, 1);
  endtask

  task automatic read_body(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == refm[exp_ptr], req, "read byte", b, refm[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    chk(sda_oe == 1'b0, "R9", "released after host nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic do_read_cur(input int n);
    bit ack;
    bus_start();
    send_byte(selb(1'b1), ack);
    chk(ack, "R8", "read selector ack", ack, 1);
    read_body(n, "R8");
  endtask

  task automatic do_read_rand(input logic [7:0] a, input int n);
    bit ack;
    bus_start();
    send_byte(selb(1'b0), ack);
    chk(ack, "R10", "dummy write selector ack", ack, 1);
    send_byte(a, ack);
    chk(ack, "R10", "dummy write address ack", ack, 1);
    bus_start();
    send_byte(selb(1'b1), ack);
    chk(ack, "R10", "read selector after repeated start", ack, 1);
    exp_ptr = a;
    read_body(n, "R10");
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 256; k++) refm[k] = 8'(k * 7 + 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R3", "reset sda_oe", sda_oe, 0);
    chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R3", "reset write strobes",
        {wr_valid, wr_commit}, 0);

    begin : wrong_sel
      bit ack;
      int c0;
      c0 = n_commit;
      bus_start();
      send_byte({4'b1010, 3'b100, 1'b0}, ack);
      chk(!ack, "R1", "select mismatch nack", ack, 0);
      send_byte(8'h00, ack);
      chk(!ack, "R2", "ignored after mismatch", ack, 0);
      send_byte(8'h00, ack);
      chk(!ack, "R2", "still ignored", ack, 0);
      bus_stop();
      tq();
      chk(n_commit == c0 && cap_n == 0, "R2", "no write from ignored bytes", cap_n, 0);
      bus_start();
      send_byte({4'b1011, SEL, 1'b0}, ack);
      chk(!ack, "R1", "wrong control code nack", ack, 0);
      bus_stop();
    end

    wbuf[0] = 8'h5A;
    do_write(8'h10, 1);
    do_read_cur(1);            // R8: byte at 11h
    do_read_rand(8'h10, 1);    // R10
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'hC0 + i);
    do_write(8'hFC, 8);        // R7 wrap in a page write
    chk(exp_ptr == 8'h04, "R7", "bench pointer after wrap", exp_ptr, 4);
    do_read_cur(2);            // R7 continues from 04h
    do_read_rand(8'hFE, 4);    // R9 and R7: FE FF 00 01

    begin : rstart_no_commit
      bit ack;
      int c0;
      logic [7:0] b;
      c0 = n_commit;
      bus_start();
      send_byte(selb(1'b0), ack);
      send_byte(8'h40, ack);
      send_byte(8'h77, ack);
      chk(ack, "R6", "data ack before repeated start", ack, 1);
      bus_start();
      send_byte(selb(1'b1), ack);
      recv_byte(1'b0, b);
      chk(b == refm[8'h41], "R6", "read after uncommitted byte", b, refm[8'h41]);
      bus_stop();
      tq();
      chk(n_commit == c0, "R6", "no commit after repeated start", n_commit - c0, 0);
      chk(mem[8'h40] == refm[8'h40], "R6", "memory unchanged", mem[8'h40], refm[8'h40]);
      flush_tok++;
      tq();
    end

    wbuf[0] = 8'h00;
    do_write(8'h20, 1);
    begin : recovery
      bit ack;
      bit v;
      bit hi;
      int cyc;
      bus_start();
      send_byte(selb(1'b0), ack);
      send_byte(8'h20, ack);
      bus_start();
      send_byte(selb(1'b1), ack);
      for (int i = 0; i < 3; i++) rbit(v);
      chk(sda_bus == 1'b0 || v == 1'b0, "R12", "engine driving zeros at abort", v, 0);
      hi = 1'b0;
      cyc = 0;
      sda_h = 1'b1;
      for (int i = 0; i < 9 && !hi; i++) begin
        tq();
        scl_h = 1'b1; tq();
        cyc++;
        if (sda_bus) begin
          hi = 1'b1;
          sda_h = 1'b0; tq();
          scl_h = 1'b0; tq();
        end else begin
          tq();
          scl_h = 1'b0; tq();
        end
      end
      chk(hi, "R12", "bus high within nine clocks", cyc, 9);
      send_byte(selb(1'b0), ack);
      chk(ack, "R12", "selector ack after recovery", ack, 1);
      send_byte(8'h30, ack);
      bus_start();
      send_byte(selb(1'b1), ack);
      exp_ptr = 8'h30;
      read_body(1, "R12");
    end

    begin : random_phase
      int unsigned s;
      s = $urandom(32'd20240611);
      for (int it = 0; it < 16; it++) begin
        int op;
        int n;
        logic [7:0] a;
        op = int'($urandom % 3);
        a  = 8'($urandom);
        if (op == 0) begin
          n = 1 + int'($urandom % 8);
          for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
          do_write(a, n);
        end else if (op == 1) begin
          do_read_cur(1 + int'($urandom % 4));
        end else begin
          do_read_rand(a, 1 + int'($urandom % 4));
        end
      end
    end

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end
endmodule